// File: doc/BRIEF.md
# Per-Core Quality-of-Service Miss Weight Generator

This block limits how much any one core can be slowed down when its evicted lines are pushed into other cores' private caches. For each core it keeps two running miss counts: all misses, and the misses that fall in the sets that always push their victims elsewhere. Scaling the second count by the ratio of all sets to those sampling sets gives an estimate of the misses the core would have had with no spilling. The surplus of real misses over that estimate, times a fixed memory latency, is the number of cycles the core has lost. That loss divided by the elapsed cycles is the core's penalty.

Once per epoch the penalty is recomputed by a multi-cycle restoring divider, one per core. The result is held in an 8-bit register with two fraction bits. It is turned into a miss weight equal to one plus 256 times the penalty, and that weight replaces the unit step with which the core's misses move the policy selection counters. The counters keep running across epochs. A single shared cycle counter provides the elapsed time. When that counter or any miss counter would wrap, every counter is halved in the same cycle, so the ratios survive.

Top module: `qos_penalty_unit`

## Requirements
- R1: During and after reset every core's weight output is 4, which is 1.0 in the output format (unsigned, two fraction bits).
- R2: Per core, the total counter adds one for each cycle with `miss_i[c]` high. The spill-set counter adds one when `miss_i[c]` and `miss_spill_set_i[c]` are both high. The estimated baseline misses are the spill-set count shifted left by `SPILL_SHIFT` (5 by default, a factor of 32).
- R3: At each epoch boundary the penalty code is floor(4 × `MEM_LAT` × (total − estimate) / cycles). It is taken from the counter values held just before that boundary edge, where cycles is the shared cycle counter.
- R4: When the total count does not exceed the estimate, the penalty code is 0 and the weight is 4.
- R5: A quotient above 255 saturates to penalty code 255 (63.75).
- R6: The weight output of a core is 4 + 256 × its penalty code, in a 16-bit field with two fraction bits. Core c occupies bits [16c+15:16c].
- R7: The penalty is sampled once every `EPOCH_LEN` cycles. The first sample is taken at the `EPOCH_LEN`-th clock edge after reset is released, and the counters are not cleared by it.
- R8: After an epoch boundary each weight keeps its previous value until that core's divider finishes. The division takes one cycle per dividend bit.
- R9: If the cycle counter is all ones, or a core's total counter is all ones while that core misses, then on that edge all counters are first halved (shift right by one) and then incremented. In particular, an all-ones cycle counter becomes 2^(CYC_W−1).
- R10: Each core's weight depends only on its own miss inputs and the shared cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_i | input | NUM_CORES | Per-core miss event, one per cycle at most |
| miss_spill_set_i | input | NUM_CORES | Marks the miss as falling in the core's always-spill sampling sets |
| weight_o | output | NUM_CORES*16 | Per-core miss weight, unsigned with two fraction bits |

## Verification
The bench sets three kinds of core against each other. The first has a light miss rate, so its penalty lands strictly between zero and saturation, and any error in scaling, in shift position or in the fraction bits shows up as a wrong code. The second has a heavy miss rate, which a design without the saturation clamp would wrap into a small weight. The third has many misses flagged as spill-set misses; a design that lets the subtraction go negative would produce a huge weight instead of 1.0. A long stretch of back-to-back misses drives the total and cycle counters through their wrap points. A design that halves only one counter, or none, would give a penalty far from the ratio the bench expects. Right after every boundary the bench also checks that the old weight is still shown, so a design that publishes its partial quotient is caught.

// File: rtl/qos_pkg.sv
package qos_pkg;

    localparam int PEN_W     = 8;   // penalty code width, 6.2 fixed point
    localparam int PEN_FRAC  = 2;   // fraction bits of penalty and weight
    localparam int WGT_W     = 16;  // miss weight width, two fraction bits
    localparam int WGT_SHIFT = 8;   // weight scale factor 256 = 1 << 8

    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;

    typedef struct packed {
        logic miss;
        logic in_spill;
    } miss_ev_t;

    // weight = 1.0 + 256 * penalty, both with two fraction bits
    function automatic logic [WGT_W-1:0] pen_to_weight(input logic [PEN_W-1:0] pen);
        return WGT_W'(1 << PEN_FRAC) + (WGT_W'(pen) << WGT_SHIFT);
    endfunction

endpackage

// File: rtl/qos_miss_counters.sv
module qos_miss_counters
    import qos_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CNT_W     = 24,
    parameter int CYC_W     = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_CORES-1:0]         miss_i,
    input  logic [NUM_CORES-1:0]         spill_i,
    output logic [CYC_W-1:0]             cyc_o,
    output logic [NUM_CORES*CNT_W-1:0]   total_o,
    output logic [NUM_CORES*CNT_W-1:0]   spill_o
);

    logic [CYC_W-1:0] cyc_q;
    logic [CNT_W-1:0] tot_q [NUM_CORES];
    logic [CNT_W-1:0] spl_q [NUM_CORES];
    miss_ev_t         ev    [NUM_CORES];
    logic             halve;

    always_comb begin
        for (int c = 0; c < NUM_CORES; c++) begin
            ev[c].miss     = miss_i[c];
            ev[c].in_spill = miss_i[c] & spill_i[c];
        end
    end

    always_comb begin
        halve = &cyc_q;
        for (int c = 0; c < NUM_CORES; c++) begin
            if ((ev[c].miss && (&tot_q[c])) || (ev[c].in_spill && (&spl_q[c])))
                halve = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= '0;
            for (int c = 0; c < NUM_CORES; c++) begin
                tot_q[c] <= '0;
                spl_q[c] <= '0;
            end
        end else begin
            cyc_q <= (halve ? (cyc_q >> 1) : cyc_q) + CYC_W'(1);
            for (int c = 0; c < NUM_CORES; c++) begin
                tot_q[c] <= (halve ? (tot_q[c] >> 1) : tot_q[c]) + CNT_W'(ev[c].miss);
                spl_q[c] <= (halve ? (spl_q[c] >> 1) : spl_q[c]) + CNT_W'(ev[c].in_spill);
            end
        end
    end

    assign cyc_o = cyc_q;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_out
        assign total_o[c*CNT_W +: CNT_W] = tot_q[c];
        assign spill_o[c*CNT_W +: CNT_W] = spl_q[c];
    end

endmodule

// File: rtl/qos_divider.sv
module qos_divider
    import qos_pkg::*;
#(
    parameter int DD_W = 35,
    parameter int DV_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [DD_W-1:0] dividend_i,
    input  logic [DV_W-1:0] divisor_i,
    output logic            done_o,
    output logic [DD_W-1:0] quot_o
);

    localparam int STEP_W = $clog2(DD_W);

    div_state_e        state_q;
    logic [STEP_W-1:0] step_q;
    logic [DD_W-1:0]   dq_q;     // dividend shifting out, quotient shifting in
    logic [DV_W-1:0]   rem_q;
    logic [DV_W-1:0]   dv_q;
    logic              done_q;
    logic [DV_W:0]     trial;
    logic              fits;

    assign trial = {rem_q, dq_q[DD_W-1]};
    assign fits  = trial >= {1'b0, dv_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIV_IDLE;
            step_q  <= '0;
            dq_q    <= '0;
            rem_q   <= '0;
            dv_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                state_q <= DIV_RUN;
                step_q  <= '0;
                dq_q    <= dividend_i;
                rem_q   <= '0;
                dv_q    <= divisor_i;
            end else if (state_q == DIV_RUN) begin
                rem_q  <= fits ? DV_W'(trial - {1'b0, dv_q}) : DV_W'(trial);
                dq_q   <= {dq_q[DD_W-2:0], fits};
                step_q <= step_q + STEP_W'(1);
                if (step_q == STEP_W'(DD_W - 1)) begin
                    state_q <= DIV_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign quot_o = dq_q;

endmodule

// File: rtl/qos_penalty_unit.sv
module qos_penalty_unit
    import qos_pkg::*;
#(
    parameter int NUM_CORES   = 4,
    parameter int CNT_W       = 24,
    parameter int CYC_W       = 32,
    parameter int SPILL_SHIFT = 5,
    parameter int MEM_LAT     = 300,
    parameter int EPOCH_LEN   = 5000000
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_CORES-1:0]         miss_i,
    input  logic [NUM_CORES-1:0]         miss_spill_set_i,
    output logic [NUM_CORES*WGT_W-1:0]   weight_o
);

    localparam int LAT_W  = $clog2(MEM_LAT + 1);
    localparam int PROD_W = CNT_W + LAT_W;
    localparam int DD_W   = PROD_W + PEN_FRAC;
    localparam int EST_W  = CNT_W + SPILL_SHIFT;
    localparam int EP_W   = $clog2(EPOCH_LEN);

    logic [CYC_W-1:0]           cyc_cnt;
    logic [NUM_CORES*CNT_W-1:0] tot_flat;
    logic [NUM_CORES*CNT_W-1:0] spill_flat;
    logic [NUM_CORES-1:0]       div_done;
    logic [EP_W-1:0]            ep_q;
    logic                       epoch_end;

    qos_miss_counters #(
        .NUM_CORES (NUM_CORES),
        .CNT_W     (CNT_W),
        .CYC_W     (CYC_W)
    ) u_counters (
        .clk     (clk),
        .rst     (rst),
        .miss_i  (miss_i),
        .spill_i (miss_spill_set_i),
        .cyc_o   (cyc_cnt),
        .total_o (tot_flat),
        .spill_o (spill_flat)
    );

    assign epoch_end = (ep_q == EP_W'(EPOCH_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst)            ep_q <= '0;
        else if (epoch_end) ep_q <= '0;
        else                ep_q <= ep_q + EP_W'(1);
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic [CNT_W-1:0] tot;
        logic [CNT_W-1:0] spl;
        logic [EST_W-1:0] est;
        logic [CNT_W-1:0] surplus;
        logic [PROD_W-1:0] extra;
        logic [DD_W-1:0]  dividend;
        logic [DD_W-1:0]  quot;
        logic [PEN_W-1:0] pen_q;

        assign tot      = tot_flat[c*CNT_W +: CNT_W];
        assign spl      = spill_flat[c*CNT_W +: CNT_W];
        assign est      = EST_W'(spl) << SPILL_SHIFT;
        assign surplus  = (EST_W'(tot) > est) ? CNT_W'(EST_W'(tot) - est) : '0;
        assign extra    = PROD_W'(surplus) * PROD_W'(MEM_LAT);
        assign dividend = {extra, {PEN_FRAC{1'b0}}};

        qos_divider #(
            .DD_W (DD_W),
            .DV_W (CYC_W)
        ) u_div (
            .clk        (clk),
            .rst        (rst),
            .start_i    (epoch_end),
            .dividend_i (dividend),
            .divisor_i  (cyc_cnt),
            .done_o     (div_done[c]),
            .quot_o     (quot)
        );

        always_ff @(posedge clk) begin
            if (rst)
                pen_q <= '0;
            else if (div_done[c])
                pen_q <= (|quot[DD_W-1:PEN_W]) ? {PEN_W{1'b1}} : quot[PEN_W-1:0];
        end

        assign weight_o[c*WGT_W +: WGT_W] = pen_to_weight(pen_q);
    end

endmodule

// File: rtl/qos_penalty_checker.sv
module qos_penalty_checker
    import qos_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CNT_W     = 24,
    parameter int CYC_W     = 32
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         start,
    input logic [NUM_CORES-1:0]         done,
    input logic [NUM_CORES*WGT_W-1:0]   weight,
    input logic [CYC_W-1:0]             cyc,
    input logic [NUM_CORES*CNT_W-1:0]   tot,
    input logic [NUM_CORES*CNT_W-1:0]   spill
);

    AST_CYC_HALVE: assert property (@(posedge clk) disable iff (rst)
        (&cyc) |=> (cyc == {1'b1, {(CYC_W-1){1'b0}}})); // R9

    AST_START_SPACING: assert property (@(posedge clk) disable iff (rst)
        start |=> !start); // R7

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
        AST_RESET_WEIGHT: assert property (@(posedge clk)
            rst |=> (weight[c*WGT_W +: WGT_W] == WGT_W'(4))); // R1

        AST_SPILL_LE_TOTAL: assert property (@(posedge clk) disable iff (rst)
            spill[c*CNT_W +: CNT_W] <= tot[c*CNT_W +: CNT_W]); // R2

        AST_WEIGHT_HOLD: assert property (@(posedge clk) disable iff (rst)
            !done[c] |=> $stable(weight[c*WGT_W +: WGT_W])); // R8

        AST_WEIGHT_FORM: assert property (@(posedge clk) disable iff (rst)
            weight[c*WGT_W +: 8] == 8'h04); // R6
    end

endmodule

bind qos_penalty_unit qos_penalty_checker #(
    .NUM_CORES (NUM_CORES),
    .CNT_W     (CNT_W),
    .CYC_W     (CYC_W)
) u_qos_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (epoch_end),
    .done   (div_done),
    .weight (weight_o),
    .cyc    (cyc_cnt),
    .tot    (tot_flat),
    .spill  (spill_flat)
);

// File: tb/test_qos_penalty_unit.sv
module test_qos_penalty_unit;

    localparam int NC     = 2;
    localparam int CNT_W  = 12;
    localparam int CYC_W  = 14;
    localparam int SHIFT  = 5;
    localparam int LAT    = 300;
    localparam int EPOCH  = 128;
    localparam int CNT_MAX = (1 << CNT_W) - 1;
    localparam int CYC_MAX = (1 << CYC_W) - 1;

    typedef struct packed {
        logic        halved;
        logic [31:0] w;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NC-1:0]   miss = '0;
    logic [NC-1:0]   spl  = '0;
    logic [NC*16-1:0] weight;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    exp_t exp_q[$];
    logic [31:0] prev_w = {16'd4, 16'd4};

    int m_cyc, m_ep;
    int m_tot [NC];
    int m_sp  [NC];
    bit m_halved;

    always #2.5 clk = ~clk;

    qos_penalty_unit #(
        .NUM_CORES   (NC),
        .CNT_W       (CNT_W),
        .CYC_W       (CYC_W),
        .SPILL_SHIFT (SHIFT),
        .MEM_LAT     (LAT),
        .EPOCH_LEN   (EPOCH)
    ) i_qos_penalty_unit (
        .clk              (clk),
        .rst              (rst),
        .miss_i           (miss),
        .miss_spill_set_i (spl),
        .weight_o         (weight)
    );

    function automatic logic [15:0] exp_weight(int t, int s, int cy);
        longint est = longint'(s) << SHIFT;
        longint d   = (longint'(t) > est) ? longint'(t) - est : 0;
        longint q   = (d * LAT * 4) / cy;
        if (q > 255) q = 255;
        return 16'(4 + 256 * q);
    endfunction

    // reference model of the counters, built from R2, R7 and R9
    always @(posedge clk) begin
        if (rst) begin
            m_cyc = 0; m_ep = 0; m_halved = 0;
            for (int c = 0; c < NC; c++) begin m_tot[c] = 0; m_sp[c] = 0; end
        end else begin
            bit hv;
            if (m_ep == EPOCH - 1) begin
                exp_t it;
                it.halved = m_halved;
                it.w = '0;
                for (int c = 0; c < NC; c++)
                    it.w[c*16 +: 16] = exp_weight(m_tot[c], m_sp[c], m_cyc);
                exp_q.push_back(it);
            end
            hv = (m_cyc == CYC_MAX);
            for (int c = 0; c < NC; c++)
                if (miss[c] && m_tot[c] == CNT_MAX) hv = 1;
            if (hv) m_halved = 1;
            m_cyc = (hv ? m_cyc / 2 : m_cyc) + 1;
            for (int c = 0; c < NC; c++) begin
                m_tot[c] = (hv ? m_tot[c] / 2 : m_tot[c]) + int'(miss[c]);
                m_sp[c]  = (hv ? m_sp[c] / 2 : m_sp[c]) + int'(miss[c] && spl[c]);
            end
            m_ep = (m_ep == EPOCH - 1) ? 0 : m_ep + 1;
        end
    end

    function automatic string tag_of(logic [15:0] w, bit hv);
        string t;
        if (w == 16'd4)                   t = "R4";
        else if (w == 16'(4 + 256 * 255)) t = "R5";
        else                              t = "R3";
        if (hv) t = {t, " R9"};
        return {t, " R2 R6 R7 R10"};
    endfunction

    // monitor: hold check right after boundary, result check later
    initial begin
        forever begin
            exp_t it;
            wait (exp_q.size() != 0);
            @(negedge clk);
            for (int c = 0; c < NC; c++) begin
                checks++;
                if (weight[c*16 +: 16] !== prev_w[c*16 +: 16]) begin
                    failures++;
                    $display("FAIL R8 core%0d hold actual=%0d expected=%0d",
                             c, weight[c*16 +: 16], prev_w[c*16 +: 16]);
                end
            end
            repeat (60) @(negedge clk);
            it = exp_q.pop_front();
            for (int c = 0; c < NC; c++) begin
                checks++;
                if (weight[c*16 +: 16] !== it.w[c*16 +: 16]) begin
                    failures++;
                    $display("FAIL %s core%0d actual=%0d expected=%0d",
                             tag_of(it.w[c*16 +: 16], it.halved), c,
                             weight[c*16 +: 16], it.w[c*16 +: 16]);
                end
            end
            prev_w = it.w;
        end
    end

    // driver: per-core miss rate and spill-set fraction, in percent
    task automatic drive(int n, int rm0, int rs0, int rm1, int rs1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            miss[0] = ($urandom_range(99) < rm0);
            spl[0]  = miss[0] && ($urandom_range(99) < rs0);
            miss[1] = ($urandom_range(99) < rm1);
            spl[1]  = miss[1] && ($urandom_range(99) < rs1);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            checks++;
            if (weight[c*16 +: 16] !== 16'd4) begin
                failures++;
                $display("FAIL R1 core%0d reset actual=%0d expected=4", c, weight[c*16 +: 16]);
            end
        end
        rst = 1'b0;
        drive(3 * EPOCH, 3, 0, 40, 0);      // mid penalty vs saturation
        drive(4 * EPOCH, 5, 50, 0, 0);      // spill-heavy clamp to zero
        drive(160 * EPOCH, 100, 0, 2, 0);   // counter wrap and halving
        drive(100, 0, 0, 0, 0);
        @(negedge clk);
        miss = '0; spl = '0;
        wait (exp_q.size() == 0);
        repeat (70) @(negedge clk);
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            failures++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule